// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts the direction of conditional branches. Its state is a table of entries. A few low bits of the branch address select the entry. Each entry holds one small saturating counter for every pattern that a global outcome history can take. The history register keeps the directions of the most recent resolved branches. On a lookup, the history picks which counter of the addressed entry gives the answer. Two branches that sit at the same address can therefore be predicted differently, depending on how the branches just before them went.

The block has a lookup side and a training side. Fetch logic presents a branch address and reads back, in the same cycle, a taken or not-taken guess together with the history value used to make it. Fetch keeps that history value with the branch. When the branch resolves, the pipeline presents the address, the saved history value and the real direction on the update port. The addressed counter moves one step toward that direction, and the direction is shifted into the history.

The update side is a valid/ready stream. Ready is held high at all times, so the block never applies back-pressure: every cycle in which valid is high delivers exactly one update. The storage is m history bits, plus entries × 2^m × n counter bits.

Top module: `cbp_correlating_predictor`

## Requirements
- R1: After reset every counter holds zero and the history holds zero. Every lookup then returns not-taken and reports history 0.
- R2: The lookup output pred_taken is the most significant bit of one counter. That counter is the one whose slot equals the current history, in the entry whose index equals pred_pc[log2(ENTRIES)+1:2]. The output is combinational from the stored state, so an update accepted at a clock edge is visible in the lookup right after that edge.
- R3: A taken update to a counter that already holds its maximum value (2^n − 1) leaves it at that maximum.
- R4: A not-taken update to a counter that already holds zero leaves it at zero.
- R5: Each accepted update shifts the history left by one bit, places upd_taken (1 = taken) in bit 0 and drops the oldest bit. The new history appears on pred_hist in the following cycle.
- R6: An accepted update with a counter below the limit changes exactly one counter: the one at slot upd_hist of the entry selected by upd_pc[log2(ENTRIES)+1:2]. A taken update adds one to it and a not-taken update subtracts one. Every other slot and every other entry keeps its value.
- R7: Address bits [1:0], and every address bit above the index field, have no effect on which entry is read or trained.
- R8: upd_ready is always 1. In a cycle with upd_valid low, neither the history nor any counter changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Current global history, to be saved with the branch |
| upd_valid | input | 1 | Update beat present |
| upd_ready | output | 1 | Update accepted; constant 1 |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History value saved at lookup time |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest case to reach from the ports is reading a trained counter in a slot other than the one that was just used. Training shifts the history, so after training the history has usually moved away from the slot that was trained. The bench steers the history back to a chosen slot by sending updates to an unrelated address with the needed directions, and then looks up the trained address. A long pseudo-random phase also sends upd_hist values that differ from the live history. A behavioural table in the bench, indexed by address and slot, is compared with both outputs on every cycle.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/cbp_sat_counter.sv
module cbp_sat_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  cbp_pkg::dir_e dir,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      if (dir == cbp_pkg::DIR_TAKEN) begin
        if (cnt != TOP) cnt <= cnt + 1'b1;
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [M-1:0] hist
);
  logic [M-1:0] nxt;

  generate
    if (M == 1) begin : g_single
      assign nxt = din;
    end else begin : g_multi
      assign nxt = {hist[M-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (shift_en) hist <= nxt;
  end
endmodule

// File: rtl/cbp_table.sv
module cbp_table #(
  parameter int ENTRIES = 16,
  parameter int HIST_W  = 2,
  parameter int CTR_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SLOTS  = 1 << HIST_W,
  localparam int BITS   = ENTRIES * SLOTS * CTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [HIST_W-1:0] rd_slot,
  output logic [CTR_W-1:0]  rd_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HIST_W-1:0] wr_slot,
  input  cbp_pkg::dir_e     wr_dir,
  output logic [BITS-1:0]   cnt_flat
);
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(e)) && (wr_slot == HIST_W'(s));
        cbp_sat_counter #(.W(CTR_W)) u_ctr (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (hit),
          .dir   (wr_dir),
          .cnt   (cnt_flat[(e*SLOTS+s)*CTR_W +: CTR_W])
        );
      end
    end
  endgenerate

  int rd_base;
  always_comb begin
    rd_base = (int'(rd_idx) * SLOTS + int'(rd_slot)) * CTR_W;
    rd_ctr  = cnt_flat[rd_base +: CTR_W];
  end
endmodule

// File: rtl/cbp_correlating_predictor.sv
module cbp_correlating_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int HIST_W  = 2,
  parameter int CTR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SLOTS = 1 << HIST_W;
  localparam int BITS  = ENTRIES * SLOTS * CTR_W;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [CTR_W-1:0] rd_ctr;
  logic [BITS-1:0]  cnt_flat;
  logic             accept;
  cbp_pkg::dir_e    wr_dir;

  assign rd_idx    = pred_pc[IDX_W+1:2];
  assign wr_idx    = upd_pc[IDX_W+1:2];
  assign upd_ready = 1'b1;
  assign accept    = upd_valid && upd_ready;
  assign wr_dir    = cbp_pkg::dir_e'(upd_taken);

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_W+2], pred_pc[1:0],
                            upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

  cbp_history #(.M(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (upd_taken),
    .hist     (pred_hist)
  );

  cbp_table #(.ENTRIES(ENTRIES), .HIST_W(HIST_W), .CTR_W(CTR_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_slot  (pred_hist),
    .rd_ctr   (rd_ctr),
    .wr_en    (accept),
    .wr_idx   (wr_idx),
    .wr_slot  (upd_hist),
    .wr_dir   (wr_dir),
    .cnt_flat (cnt_flat)
  );

  assign pred_taken = rd_ctr[CTR_W-1];
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int HIST_W  = 2,
  parameter int CTR_W   = 2,
  localparam int SLOTS  = 1 << HIST_W,
  localparam int BITS   = ENTRIES * SLOTS * CTR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic [PC_W-1:0]   upd_pc,
  input logic [HIST_W-1:0] upd_hist,
  input logic              upd_taken,
  input logic [BITS-1:0]   cnt_flat
);
  localparam logic [CTR_W-1:0] TOP = '1;

  int pred_base, upd_base;
  logic [CTR_W-1:0] upd_cur;
  logic [HIST_W-1:0] hist_exp;
  always_comb begin
    pred_base = ((int'(pred_pc >> 2) % ENTRIES) * SLOTS + int'(pred_hist)) * CTR_W;
    upd_base  = ((int'(upd_pc >> 2) % ENTRIES) * SLOTS + int'(upd_hist)) * CTR_W;
    upd_cur   = cnt_flat[upd_base +: CTR_W];
    hist_exp  = HIST_W'({pred_hist, upd_taken});
  end

  p_pred_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == cnt_flat[pred_base + CTR_W - 1]);

  p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_cur == TOP) |=> cnt_flat[$past(upd_base) +: CTR_W] == TOP);

  p_sat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur == '0) |=> cnt_flat[$past(upd_base) +: CTR_W] == '0);

  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist == $past(hist_exp));

  p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_cur != TOP) |=>
      cnt_flat[$past(upd_base) +: CTR_W] == $past(upd_cur) + 1'b1);

  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur != '0) |=>
      cnt_flat[$past(upd_base) +: CTR_W] == $past(upd_cur) - 1'b1);

  p_idle_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  p_idle_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(cnt_flat));
endmodule

bind cbp_correlating_predictor cbp_checker #(
  .PC_W(PC_W), .ENTRIES(ENTRIES), .HIST_W(HIST_W), .CTR_W(CTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_hist(upd_hist), .upd_taken(upd_taken), .cnt_flat(cnt_flat)
);

// File: tb/sim_cbp_correlating_predictor.sv
`timescale 1ns/1ps
module sim_cbp_correlating_predictor;
  localparam int PC_W = 32, ENT = 16, HW = 2, CW = 2;
  localparam int SLOTS = 1 << HW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic pred_taken, upd_ready, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [HW-1:0] pred_hist, upd_hist = '0;

  always #2 clk = ~clk;

  cbp_correlating_predictor #(.PC_W(PC_W), .ENTRIES(ENT), .HIST_W(HW), .CTR_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

  int model [ENT][SLOTS];
  int ghr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int ent_of(logic [PC_W-1:0] pc);
    return int'(pc >> 2) % ENT;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [PC_W-1:0] ppc, logic uv,
                      logic [PC_W-1:0] upc, int uh, logic ut);
    int e, exp_t;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_hist = HW'(uh); upd_taken = ut;
    #0.5;
    e = ent_of(ppc);
    exp_t = (model[e][ghr] >= (1 << (CW-1))) ? 1 : 0;
    check({tag, " taken"}, int'(pred_taken), exp_t);
    check({tag, " hist"}, int'(pred_hist), ghr);
    check("R8 ready", int'(upd_ready), 1);
    @(posedge clk);
    if (uv) begin
      e = ent_of(upc);
      if (ut && model[e][uh] < MAXC) model[e][uh]++;
      if (!ut && model[e][uh] > 0) model[e][uh]--;
      ghr = ((ghr << 1) | int'(ut)) & (SLOTS - 1);
    end
  endtask

  task automatic steer(int target);
    for (int b = HW - 1; b >= 0; b--)
      step("R5 steer", 32'h0000_0100, 1'b1, 32'h0000_0030, ghr, 1'(target >> b));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < ENT; i++) for (int j = 0; j < SLOTS; j++) model[i][j] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: all lookups not-taken with history 0 after reset
    for (int i = 0; i < ENT; i++) step("R1 reset", 32'(i * 4), 1'b0, '0, 0, 1'b0);
    // R3: saturate slot 2 of entry 0 upward, then read it back
    for (int i = 0; i < 5; i++) step("R3 up", 32'h40, 1'b1, 32'h40, 2, 1'b1);
    steer(2);
    step("R3 read slot2", 32'h40, 1'b0, '0, 0, 1'b0);
    steer(1);
    step("R6 other slot", 32'h40, 1'b0, '0, 0, 1'b0);
    // R4: drain slot 2 of entry 0 below zero
    for (int i = 0; i < 5; i++) step("R4 down", 32'h40, 1'b1, 32'h40, 2, 1'b0);
    steer(2);
    step("R4 read slot2", 32'h40, 1'b0, '0, 0, 1'b0);
    // R7: train entry 5 slot 0 and look it up through aliased addresses
    for (int i = 0; i < 3; i++) step("R7 train", 32'h14, 1'b1, 32'h17, 0, 1'b1);
    steer(0);
    step("R7 alias lo", 32'h15, 1'b0, '0, 0, 1'b0);
    step("R7 alias hi", 32'h14 + 32'(ENT * 4), 1'b0, '0, 0, 1'b0);
    step("R7 alias top", 32'hF000_0016, 1'b0, '0, 0, 1'b0);
    step("R7 neighbour", 32'h18, 1'b0, '0, 0, 1'b0);
    // R8: idle cycles with live-looking update fields
    for (int i = 0; i < 20; i++) step("R8 idle", 32'h14, 1'b0, 32'h14, 0, 1'b0);
    for (int i = 0; i < 8; i++) step("R8 idle", 32'h40, 1'b0, 32'h40, 2, 1'b1);
    // R2 R5 R6: pseudo-random mix
    lf = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R2 R5 R6 mix", {24'h0, lf[7:0]}, lf[9] | lf[10], {24'h0, lf[17:10]},
           lf[11] ? int'(lf[13:12]) : ghr, lf[20]);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule